// File: doc/BRIEF.md
# GPIO Interrupt and Wake Event Detector

This block watches a bank of already-synchronized, glitch-filtered GPIO inputs and turns their activity into interrupt and wake requests. Each pin is set up on its own. It can latch a rising edge, a falling edge, or either edge. It can also report a level, with its polarity chosen per pin. Edge detection compares each input with a copy of itself delayed by one cycle. Latched events collect in a pending-source register, which software clears by writing ones. A mask register chooses which pending sources drive the single combined interrupt line.

Alongside the interrupt path, a wake-enable register selects pins whose events also set a wake status bit. Wake status is cleared by writing ones, and the OR of the wake status bits drives a wake request line. The block hangs off the same 32-bit register bus as the pin bank. Reads return data one cycle after the request. Input conditioning and power-domain sequencing are handled elsewhere.

Top module: `gpio_event_detector`

## Requirements
- R1: After reset every register reads 0, the delayed input copy is 0, and irq_out, wake_out and bus_rdata are low.
- R2: In edge mode (input-type bit 0), the pending bit of pin i sets one cycle after pin i goes from 0 to 1 if bit i of the rising-enable register (offset 0x064) is 1. It also sets one cycle after pin i goes from 1 to 0 if bit i of the falling-enable register (offset 0x07C) is 1. With both enables set, either edge sets it. An edge in a direction that is not enabled sets nothing.
- R3: When bit i of the input-type register (offset 0x300) is 1, pin i is in level mode. Its pending bit then equals, one cycle later, pin i XOR bit i of the polarity register (offset 0x318), where a polarity of 1 means active-low. The edge enables have no effect on a level-mode pin.
- R4: The pending-source register (offset 0x0C4) reads back the pending bits. Writing 1 to bit i clears it for an edge-mode pin, and bits written 0 are left alone. For a level-mode pin the clear has no lasting effect while the level stays active.
- R5: If an enabled edge arrives in the same cycle as a clearing write to that pin's pending bit, the bit stays set.
- R6: irq_out is 1 exactly when, in the previous cycle, some pin had both its pending bit and its bit in the interrupt-mask register (offset 0x0AC) at 1. A masked source still latches and reads back as pending.
- R7: The wake status bit of pin i (offset 0x348) sets on any event of pin i (an enabled edge, or an active level) while bit i of the wake-enable register (offset 0x330) is 1. The interrupt mask does not affect it. Writing 1 clears it, but an event in the same cycle wins. wake_out is the OR of the wake status bits one cycle earlier.
- R8: A read returns on bus_rdata, one cycle after bus_rd_en, the value the register held before that edge. Configuration registers read back what was last written. Unmapped addresses read 0, and writes to them change nothing. bus_rdata is 0 in cycles after which no read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Filtered GPIO input levels |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Combined interrupt request |
| wake_out | output | 1 | Combined wake request |

## Verification
Directed pin sequences first raise and drop individual pins with only a rising enable, only a falling enable, and both enables set. This separates the direction decode from the delayed-copy compare. Level-mode pins are then driven with both polarities, and clears are attempted while the level is held, to show that level sources are recomputed rather than latched. Clearing writes are placed in the same cycle as a fresh edge, on both the pending and the wake status bits, so that the priority of set over clear is exercised. A long pseudo-random phase then mixes pin toggles with configuration writes and reads, and a behavioural model compares irq_out, wake_out and bus_rdata every cycle.

// File: rtl/gpd_pkg.sv
`timescale 1ns/1ps
package gpd_pkg;

  // Register byte offsets on the shared bus.
  localparam int unsigned OFF_RISE  = 'h064;
  localparam int unsigned OFF_FALL  = 'h07C;
  localparam int unsigned OFF_MASK  = 'h0AC;
  localparam int unsigned OFF_SRC   = 'h0C4;
  localparam int unsigned OFF_TYPE  = 'h300;
  localparam int unsigned OFF_POL   = 'h318;
  localparam int unsigned OFF_WMASK = 'h330;
  localparam int unsigned OFF_WSTAT = 'h348;

  // Index of each plain configuration register in the config array.
  localparam int NCFG      = 6;
  localparam int CFG_RISE  = 0;
  localparam int CFG_FALL  = 1;
  localparam int CFG_MASK  = 2;
  localparam int CFG_TYPE  = 3;
  localparam int CFG_POL   = 4;
  localparam int CFG_WMASK = 5;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_RISE,
    SEL_FALL,
    SEL_MASK,
    SEL_SRC,
    SEL_TYPE,
    SEL_POL,
    SEL_WMASK,
    SEL_WSTAT
  } reg_sel_e;

  // Selector that owns configuration slot idx.
  function automatic reg_sel_e cfg_sel(input int idx);
    case (idx)
      CFG_RISE:  return SEL_RISE;
      CFG_FALL:  return SEL_FALL;
      CFG_MASK:  return SEL_MASK;
      CFG_TYPE:  return SEL_TYPE;
      CFG_POL:   return SEL_POL;
      CFG_WMASK: return SEL_WMASK;
      default:   return SEL_NONE;
    endcase
  endfunction

  function automatic reg_sel_e decode_off(input logic [31:0] off);
    case (off)
      OFF_RISE:  return SEL_RISE;
      OFF_FALL:  return SEL_FALL;
      OFF_MASK:  return SEL_MASK;
      OFF_SRC:   return SEL_SRC;
      OFF_TYPE:  return SEL_TYPE;
      OFF_POL:   return SEL_POL;
      OFF_WMASK: return SEL_WMASK;
      OFF_WSTAT: return SEL_WSTAT;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpd_regs.sv
`timescale 1ns/1ps
// Configuration registers, clear strobes and registered read path.
module gpd_regs
  import gpd_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NPINS-1:0]             src_q,
  input  logic [NPINS-1:0]             wst_q,
  output logic [NCFG-1:0][NPINS-1:0]   cfg_o,
  output logic [NPINS-1:0]             src_clr,
  output logic [NPINS-1:0]             wst_clr,
  output logic [DATA_W-1:0]            rdata
);

  reg_sel_e            sel;
  logic [NPINS-1:0]    wbits;
  logic [NPINS-1:0]    rd_mux;

  assign sel   = decode_off(32'(addr));
  assign wbits = wdata[NPINS-1:0];

  // One register per configuration slot.
  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    logic [NPINS-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && (sel == cfg_sel(g))) begin
        q <= wbits;
      end
    end
    assign cfg_o[g] = q;
  end

  // Write-one-to-clear strobes for the two status registers.
  assign src_clr = (wr_en && (sel == SEL_SRC))   ? wbits : '0;
  assign wst_clr = (wr_en && (sel == SEL_WSTAT)) ? wbits : '0;

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NCFG; g++) begin
      if (sel == cfg_sel(g)) begin
        rd_mux = cfg_o[g];
      end
    end
    if (sel == SEL_SRC) begin
      rd_mux = src_q;
    end
    if (sel == SEL_WSTAT) begin
      rd_mux = wst_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= DATA_W'(rd_mux);
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/gpd_detect.sv
`timescale 1ns/1ps
// Per-pin edge and level event detection against a one-cycle delayed copy.
module gpd_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic [NPINS-1:0] lvl_sel,
  input  logic [NPINS-1:0] lvl_inv,
  output logic [NPINS-1:0] edge_hit,
  output logic [NPINS-1:0] lvl_act
);

  logic [NPINS-1:0] pin_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_d <= '0;
    end else begin
      pin_d <= pin_in;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic went_up;
    logic went_down;
    assign went_up     = pin_in[g] & ~pin_d[g];
    assign went_down   = ~pin_in[g] & pin_d[g];
    assign edge_hit[g] = ~lvl_sel[g] & ((rise_en[g] & went_up) | (fall_en[g] & went_down));
    assign lvl_act[g]  = lvl_sel[g] & (pin_in[g] ^ lvl_inv[g]);
  end

endmodule

// File: rtl/gpd_pending.sv
`timescale 1ns/1ps
// Pending-source and wake status registers with registered request outputs.
module gpd_pending #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] edge_hit,
  input  logic [NPINS-1:0] lvl_act,
  input  logic [NPINS-1:0] lvl_sel,
  input  logic [NPINS-1:0] irq_mask,
  input  logic [NPINS-1:0] wake_mask,
  input  logic [NPINS-1:0] src_clr,
  input  logic [NPINS-1:0] wst_clr,
  output logic [NPINS-1:0] src_q,
  output logic [NPINS-1:0] wst_q,
  output logic             irq_q,
  output logic             wake_q
);

  logic [NPINS-1:0] src_n;
  logic [NPINS-1:0] wst_n;
  logic [NPINS-1:0] any_evt;

  assign any_evt = edge_hit | lvl_act;

  // Level pins are recomputed every cycle; edge pins hold until cleared,
  // and a new edge beats a simultaneous clear.
  assign src_n = lvl_act | (~lvl_sel & ((src_q & ~src_clr) | edge_hit));
  assign wst_n = (wst_q & ~wst_clr) | (any_evt & wake_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      wst_q  <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      src_q  <= src_n;
      wst_q  <= wst_n;
      irq_q  <= |(src_q & irq_mask);
      wake_q <= |wst_q;
    end
  end

endmodule

// File: rtl/gpio_event_detector.sv
`timescale 1ns/1ps
module gpio_event_detector
  import gpd_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              wake_out
);

  logic [NCFG-1:0][NPINS-1:0] cfg;
  logic [NPINS-1:0] rise_q, fall_q, mask_q, type_q, pol_q, wmask_q;
  logic [NPINS-1:0] src_q, wst_q, src_clr, wst_clr;
  logic [NPINS-1:0] edge_hit, lvl_act;

  assign rise_q  = cfg[CFG_RISE];
  assign fall_q  = cfg[CFG_FALL];
  assign mask_q  = cfg[CFG_MASK];
  assign type_q  = cfg[CFG_TYPE];
  assign pol_q   = cfg[CFG_POL];
  assign wmask_q = cfg[CFG_WMASK];

  gpd_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr_en),
    .rd_en   (bus_rd_en),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .src_q   (src_q),
    .wst_q   (wst_q),
    .cfg_o   (cfg),
    .src_clr (src_clr),
    .wst_clr (wst_clr),
    .rdata   (bus_rdata)
  );

  gpd_detect #(.NPINS(NPINS)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin_in),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .lvl_sel  (type_q),
    .lvl_inv  (pol_q),
    .edge_hit (edge_hit),
    .lvl_act  (lvl_act)
  );

  gpd_pending #(.NPINS(NPINS)) u_pending (
    .clk       (clk),
    .rst       (rst),
    .edge_hit  (edge_hit),
    .lvl_act   (lvl_act),
    .lvl_sel   (type_q),
    .irq_mask  (mask_q),
    .wake_mask (wmask_q),
    .src_clr   (src_clr),
    .wst_clr   (wst_clr),
    .src_q     (src_q),
    .wst_q     (wst_q),
    .irq_q     (irq_out),
    .wake_q    (wake_out)
  );

endmodule

// File: rtl/gpd_checker.sv
`timescale 1ns/1ps
module gpd_checker #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pin_in,
  input logic             irq_out,
  input logic             wake_out,
  input logic [NPINS-1:0] src,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] wst,
  input logic [NPINS-1:0] type_sel,
  input logic [NPINS-1:0] pol,
  input logic [NPINS-1:0] rise
);

  logic [NPINS-1:0] pin_seen;
  logic [NPINS-1:0] up_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_seen <= '0;
    end else begin
      pin_seen <= pin_in;
    end
  end

  assign up_hit = ~type_sel & rise & pin_in & ~pin_seen;

  // R1: reset empties both status registers and drops both requests
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (src == '0 && wst == '0 && !irq_out && !wake_out));

  // R2 and R5: an enabled rising edge always leaves its pending bit set
  assert_edge_latches_R2: assert property (@(posedge clk) disable iff (rst)
    (up_hit != '0) |=> ((src & $past(up_hit)) == $past(up_hit)));

  // R3: level pins track pin XOR polarity one cycle later
  assert_level_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    (type_sel != '0) |=> ((src & $past(type_sel)) == $past(type_sel & (pin_in ^ pol))));

  // R6: combined interrupt follows masked pending bits one cycle later
  assert_irq_combine_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(src & mask))));

  // R7: wake request follows wake status one cycle later
  assert_wake_combine_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wake_out == $past(|wst)));

endmodule

bind gpio_event_detector gpd_checker #(.NPINS(NPINS)) u_gpd_checker (
  .clk      (clk),
  .rst      (rst),
  .pin_in   (pin_in),
  .irq_out  (irq_out),
  .wake_out (wake_out),
  .src      (src_q),
  .mask     (mask_q),
  .wst      (wst_q),
  .type_sel (type_q),
  .pol      (pol_q),
  .rise     (rise_q)
);

// File: tb/gpio_event_detector_test.sv
`timescale 1ns/1ps
module gpio_event_detector_test;

  localparam int NP = 32;
  localparam logic [11:0] A_RISE  = 12'h064;
  localparam logic [11:0] A_FALL  = 12'h07C;
  localparam logic [11:0] A_MASK  = 12'h0AC;
  localparam logic [11:0] A_SRC   = 12'h0C4;
  localparam logic [11:0] A_TYPE  = 12'h300;
  localparam logic [11:0] A_POL   = 12'h318;
  localparam logic [11:0] A_WMASK = 12'h330;
  localparam logic [11:0] A_WSTAT = 12'h348;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic        wake_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_event_detector uut (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .wake_out  (wake_out)
  );

  // Behavioural reference model
  logic [31:0] m_rise, m_fall, m_mask, m_type, m_pol, m_wmask;
  logic [31:0] m_src, m_wst, m_prev, m_rdata;
  logic        m_irq, m_wake;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      A_RISE:  return m_rise;
      A_FALL:  return m_fall;
      A_MASK:  return m_mask;
      A_SRC:   return m_src;
      A_TYPE:  return m_type;
      A_POL:   return m_pol;
      A_WMASK: return m_wmask;
      A_WSTAT: return m_wst;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] ns, nw;
    logic        ev, clr, wclr, act;
    if (rst) begin
      m_rise = 0; m_fall = 0; m_mask = 0; m_type = 0; m_pol = 0; m_wmask = 0;
      m_src = 0; m_wst = 0; m_prev = 0; m_rdata = 0; m_irq = 0; m_wake = 0;
    end else begin
      m_irq   = (m_src & m_mask) != 0;
      m_wake  = m_wst != 0;
      m_rdata = bus_rd_en ? m_read(bus_addr) : 32'h0;
      for (int i = 0; i < NP; i++) begin
        clr  = bus_wr_en && bus_addr == A_SRC && bus_wdata[i];
        wclr = bus_wr_en && bus_addr == A_WSTAT && bus_wdata[i];
        if (m_type[i]) begin
          act   = pin_in[i] ^ m_pol[i];
          ns[i] = act;
          ev    = act;
        end else begin
          ev = (m_rise[i] && pin_in[i] && !m_prev[i]) ||
               (m_fall[i] && !pin_in[i] && m_prev[i]);
          ns[i] = (m_src[i] && !clr) || ev;
        end
        nw[i] = (m_wst[i] && !wclr) || (ev && m_wmask[i]);
      end
      m_src = ns;
      m_wst = nw;
      m_prev = pin_in;
      if (bus_wr_en) begin
        case (bus_addr)
          A_RISE:  m_rise  = bus_wdata;
          A_FALL:  m_fall  = bus_wdata;
          A_MASK:  m_mask  = bus_wdata;
          A_TYPE:  m_type  = bus_wdata;
          A_POL:   m_pol   = bus_wdata;
          A_WMASK: m_wmask = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 irq_out vs model", {31'b0, irq_out}, {31'b0, m_irq});
      chk("R7 wake_out vs model", {31'b0, wake_out}, {31'b0, m_wake});
      chk("R8 bus_rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pins(input logic [11:0] a, input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; pin_in = p;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_pins(a, d, pin_in);
  endtask

  task automatic setp(input logic [31:0] p);
    @(negedge clk);
    pin_in = p;
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    logic [31:0] rs;
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
    chk("R1 wake_out after reset", {31'b0, wake_out}, 32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd(A_SRC, 32'h0, "R1 source after reset");
    rd(A_MASK, 32'h0, "R1 mask after reset");

    wr(A_RISE, 32'h5);
    wr(A_FALL, 32'h6);
    wr(A_MASK, 32'h7);
    // R2 edge directions
    setp(32'h1);
    rd(A_SRC, 32'h1, "R2 rising edge pin0");
    chk("R6 irq with unmasked source", {31'b0, irq_out}, 32'h1);
    setp(32'h3);
    rd(A_SRC, 32'h1, "R2 rise on fall-only pin1 ignored");
    setp(32'h1);
    rd(A_SRC, 32'h3, "R2 falling edge pin1");
    setp(32'h5);
    rd(A_SRC, 32'h7, "R2 both-edge pin2 rise");
    // R4 clear
    wr(A_SRC, 32'h7);
    rd(A_SRC, 32'h0, "R4 write-one clear");
    setp(32'h1);
    rd(A_SRC, 32'h4, "R2 both-edge pin2 fall");
    wr(A_SRC, 32'h0);
    rd(A_SRC, 32'h4, "R4 zero bits untouched");
    wr(A_SRC, 32'h4);
    // R5 clear race
    setp(32'h0);
    setp(32'h1);
    setp(32'h0);
    wr_pins(A_SRC, 32'h1, 32'h1);
    rd(A_SRC, 32'h1, "R5 edge beats clear");
    wr(A_SRC, 32'h1);
    rd(A_SRC, 32'h0, "R4 clear after race");
    // R6 masking
    setp(32'h0);
    setp(32'h1);
    wr(A_MASK, 32'h6);
    idle(2);
    chk("R6 masked source no irq", {31'b0, irq_out}, 32'h0);
    rd(A_SRC, 32'h1, "R6 masked source still pending");
    wr(A_MASK, 32'h7);
    idle(2);
    chk("R6 unmask raises irq", {31'b0, irq_out}, 32'h1);
    wr(A_SRC, 32'h1);
    idle(2);
    chk("R6 irq drops after clear", {31'b0, irq_out}, 32'h0);
    // R3 level mode
    wr(A_POL, 32'h10);
    wr(A_TYPE, 32'h18);
    rd(A_SRC, 32'h10, "R3 active-low level pin4");
    wr(A_SRC, 32'h10);
    rd(A_SRC, 32'h10, "R4 level clear has no lasting effect");
    setp(32'h11);
    rd(A_SRC, 32'h0, "R3 level pin4 inactive");
    setp(32'h19);
    rd(A_SRC, 32'h8, "R3 active-high level pin3");
    wr(A_RISE, 32'hD);
    setp(32'h11);
    rd(A_SRC, 32'h0, "R3 edge enable ignored in level mode");
    // R7 wake
    wr(A_RISE, 32'h2D);
    wr(A_WMASK, 32'h20);
    setp(32'h31);
    rd(A_WSTAT, 32'h20, "R7 wake status set");
    chk("R7 wake_out raised", {31'b0, wake_out}, 32'h1);
    chk("R6 masked pin5 no irq", {31'b0, irq_out}, 32'h0);
    rd(A_SRC, 32'h20, "R6 pin5 pending while masked");
    wr(A_WSTAT, 32'h20);
    rd(A_WSTAT, 32'h0, "R7 wake status clear");
    idle(1);
    chk("R7 wake_out dropped", {31'b0, wake_out}, 32'h0);
    setp(32'h11);
    wr_pins(A_WSTAT, 32'h20, 32'h31);
    rd(A_WSTAT, 32'h20, "R7 event beats wake clear");
    setp(32'h30);
    setp(32'h31);
    rd(A_WSTAT, 32'h20, "R7 disabled pin0 no wake");
    // R8 readback and unmapped
    rd(A_RISE, 32'h2D, "R8 rise readback");
    rd(A_FALL, 32'h6, "R8 fall readback");
    rd(A_TYPE, 32'h18, "R8 type readback");
    rd(A_POL, 32'h10, "R8 polarity readback");
    rd(A_WMASK, 32'h20, "R8 wake enable readback");
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h200, 32'h0, "R8 unmapped reads zero");
    rd(A_MASK, 32'h7, "R8 unmapped write no effect");

    // Pseudo-random phase, checked against the model every cycle
    rs = 32'h1ACE_B00C;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      bus_wr_en = 1'b0; bus_rd_en = 1'b0;
      if (rs[2:0] == 3'd0 || rs[2:0] == 3'd1) pin_in = pin_in ^ (32'h1 << rs[12:8]);
      if (rs[4:3] == 2'd0) pin_in = pin_in ^ {rs[31:24], rs[7:0], rs[23:16], rs[15:8]};
      case (rs[27:25])
        3'd0: begin bus_wr_en = 1'b1; bus_addr = 12'h064 + {7'b0, rs[30:29], 3'b0} * 12'd3; bus_wdata = {rs[15:0], rs[31:16]}; end
        3'd1: begin bus_wr_en = 1'b1; bus_addr = rs[28] ? A_SRC : A_WSTAT; bus_wdata = rs; end
        3'd2: begin bus_wr_en = 1'b1; bus_addr = rs[28] ? A_TYPE : A_POL; bus_wdata = rs & {rs[7:0], rs[31:8]}; end
        3'd3: begin bus_wr_en = 1'b1; bus_addr = A_WMASK; bus_wdata = rs; end
        3'd4, 3'd5: begin
          bus_rd_en = 1'b1;
          case (rs[31:29])
            3'd0: bus_addr = A_RISE;  3'd1: bus_addr = A_FALL;
            3'd2: bus_addr = A_MASK;  3'd3: bus_addr = A_SRC;
            3'd4: bus_addr = A_TYPE;  3'd5: bus_addr = A_POL;
            3'd6: bus_addr = A_WMASK; default: bus_addr = A_WSTAT;
          endcase
        end
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    idle(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule